// File: doc/BRIEF.md
# Segment Invert/Flip Encoder

This block encodes one segment of a 16-bit data word in place. A command carries the word, a segment size code, a segment number and an opcode. The size code picks a segment width of 4, 8 or 16 bits, and the segment number picks which slice of the word that width covers. Segment number k covers bits [k*width+width-1 : k*width].

The chosen segment can be complemented, bit-reversed, or both. Either operation can be forced, or applied only when a rule says it lowers the cost of sending the segment. The rewritten word comes back with two side results: the count of set bits left in the segment and a 2-bit record of what was done.

Two further opcodes convert between pairs of 2-bit encoding records and one packed 4-bit record. A pulse-stream transmitter uses this when it sends records for two segments in a single header field, and a receiver uses it when it takes them apart. Every command produces one registered response one clock after its strobe.

Top module: `seg_codec_top`

## Requirements
- R1: The size code is 0, 1 or 2 for a 4-, 8- or 16-bit segment. A segment number whose slice runs past bit 15 makes the command a no-op: word unchanged, ones count 0, flag 0. Size code 3 also makes it a no-op. This applies to opcodes 1 to 5.
- R2: Opcode 1 (forced invert) complements every bit of the segment and reports flag 1.
- R3: Opcode 2 (conditional invert) complements the segment and reports flag 1 only when its set-bit count is more than half the width. Otherwise it leaves the segment as it is and reports flag 0.
- R4: Opcode 3 (forced flip) reverses the bit order inside the segment and reports flag 2.
- R5: Opcode 4 (conditional flip) reverses the segment and reports flag 2 only when its unsigned value is greater than the value of its reversed form. Otherwise it leaves the segment as it is and reports flag 0.
- R6: Opcode 5 complements and reverses the segment unconditionally and reports flag 3.
- R7: For opcodes 1 to 5, ones_out is the number of set bits in the resulting segment. flag_out bit 0 means inversion was applied, bit 1 means reversal was applied, and bits 7:2 are zero.
- R8: Opcode 6 (pack) gives flag_out = {4'b0, flag_a_in[1:0], flag_b_in[1:0]}. word_out equals word_in and ones_out is 0.
- R9: Opcode 7 (unpack) gives split_a_out = {6'b0, flag_a_in[3:2]} and split_b_out = {6'b0, flag_a_in[1:0]}. word_out equals word_in, and ones_out and flag_out are 0. The split outputs are 0 after any other opcode.
- R10: rsp_valid is high exactly one cycle after each cycle in which cmd_valid is high. Outputs change only on a response and are all zero after reset. Opcode 0 and opcodes 8 to 15 return word_in unchanged with every other result zero.
- R11: Bits of word_out outside the selected segment always equal those of word_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| seg_size | input | 2 | Segment size code |
| seg_num | input | 2 | Segment number |
| word_in | input | 16 | Working word |
| flag_a_in | input | 8 | First flag operand (packed source for unpack) |
| flag_b_in | input | 8 | Second flag operand |
| rsp_valid | output | 1 | Response strobe |
| word_out | output | 16 | Rewritten word |
| ones_out | output | 5 | Set-bit count of the resulting segment |
| flag_out | output | 8 | Encoding flag or packed flags |
| split_a_out | output | 8 | Upper pair from unpack |
| split_b_out | output | 8 | Lower pair from unpack |

## Verification
The hardest cases to reach are the edges of the two conditions. One is a segment with exactly half of its bits set, which must stay unchanged. The other is a segment that is a palindrome, where its value equals its reversed form, which must also stay unchanged. These rarely come up with scattered words. The stimulus therefore repeats each 4-bit value across all four nibbles, so every nibble value lands in every 4-bit slot. Those nibble palindromes also build the 8- and 16-bit tie cases. A second group of words comes from arithmetic spreading, and every size and number pair is swept, including the slices that run past the word.

// File: rtl/seg_codec_pkg.sv
package seg_codec_pkg;

    localparam int WORD_W     = 16;
    localparam int FLAG_W     = 8;
    localparam int BASE_W     = 4;
    localparam int SIZE_CODES = 3;
    localparam int CNT_W      = $clog2(WORD_W + 1);
    localparam int SPAN_W     = CNT_W + 2;

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_INV    = 4'd1,
        OP_INVC   = 4'd2,
        OP_FLP    = 4'd3,
        OP_FLPC   = 4'd4,
        OP_INVFLP = 4'd5,
        OP_PACK   = 4'd6,
        OP_UNPACK = 4'd7
    } op_e;

    typedef struct packed {
        logic              ok;
        logic [CNT_W-1:0]  width;
        logic [3:0]        shift;
        logic [WORD_W-1:0] low_mask;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] seg;
    } seg_sel_t;

    typedef struct packed {
        logic [WORD_W-1:0] seg;
        logic [1:0]        flag;
        logic [CNT_W-1:0]  ones;
    } seg_res_t;

    function automatic logic [CNT_W-1:0] count_ones(input logic [WORD_W-1:0] v);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < WORD_W; i++) begin
            acc = acc + CNT_W'(v[i]);
        end
        return acc;
    endfunction

    function automatic logic [WORD_W-1:0] reverse_in(input logic [WORD_W-1:0] v,
                                                     input logic [CNT_W-1:0]  w);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            for (int j = 0; j < WORD_W; j++) begin
                if ((CNT_W'(i) < w) && (CNT_W'(i) + CNT_W'(j) + CNT_W'(1) == w)) begin
                    r[j] = v[i];
                end
            end
        end
        return r;
    endfunction

    function automatic logic is_encode(input op_e op);
        return (op == OP_INV) || (op == OP_INVC) || (op == OP_FLP) ||
               (op == OP_FLPC) || (op == OP_INVFLP);
    endfunction

endpackage

// File: rtl/seg_select.sv
module seg_select
    import seg_codec_pkg::*;
(
    input  logic [1:0]        size_code,
    input  logic [1:0]        seg_idx,
    input  logic [WORD_W-1:0] word,
    output seg_sel_t          sel
);
    logic [CNT_W-1:0]  width;
    logic [SPAN_W-1:0] end_pos;
    logic [SPAN_W-1:0] start_pos;
    logic [WORD_W-1:0] low;

    always_comb begin
        width = '0;
        if (32'(size_code) < SIZE_CODES) begin
            width = CNT_W'(BASE_W) << size_code;
        end
        start_pos = SPAN_W'(seg_idx) * SPAN_W'(width);
        end_pos   = start_pos + SPAN_W'(width);
    end

    genvar g;
    generate
        for (g = 0; g < WORD_W; g++) begin : g_low
            assign low[g] = (CNT_W'(g) < width);
        end
    endgenerate

    always_comb begin
        sel = '0;
        if ((width != '0) && (end_pos <= SPAN_W'(WORD_W))) begin
            sel.ok       = 1'b1;
            sel.width    = width;
            sel.shift    = start_pos[3:0];
            sel.low_mask = low;
            sel.mask     = low << start_pos[3:0];
            sel.seg      = (word >> start_pos[3:0]) & low;
        end
    end
endmodule

// File: rtl/seg_transform.sv
module seg_transform
    import seg_codec_pkg::*;
(
    input  op_e      op,
    input  seg_sel_t sel,
    output seg_res_t res
);
    logic [WORD_W-1:0] inv_v;
    logic [WORD_W-1:0] rev_v;
    logic [WORD_W-1:0] both_v;
    logic [CNT_W-1:0]  ones_in;
    logic [CNT_W:0]    twice_ones;
    logic              want_inv;
    logic              want_flp;

    always_comb begin
        inv_v      = ~sel.seg & sel.low_mask;
        rev_v      = reverse_in(sel.seg, sel.width);
        both_v     = reverse_in(inv_v, sel.width);
        ones_in    = count_ones(sel.seg);
        twice_ones = {ones_in, 1'b0};
        want_inv   = twice_ones > (CNT_W + 1)'(sel.width);
        want_flp   = sel.seg > rev_v;
    end

    always_comb begin
        res = '0;
        if (sel.ok) begin
            res.seg  = sel.seg;
            res.flag = 2'b00;
            case (op)
                OP_INV: begin
                    res.seg  = inv_v;
                    res.flag = 2'b01;
                end
                OP_INVC: begin
                    if (want_inv) begin
                        res.seg  = inv_v;
                        res.flag = 2'b01;
                    end
                end
                OP_FLP: begin
                    res.seg  = rev_v;
                    res.flag = 2'b10;
                end
                OP_FLPC: begin
                    if (want_flp) begin
                        res.seg  = rev_v;
                        res.flag = 2'b10;
                    end
                end
                OP_INVFLP: begin
                    res.seg  = both_v;
                    res.flag = 2'b11;
                end
                default: res.seg = sel.seg;
            endcase
            res.ones = count_ones(res.seg);
        end
    end

    always_comb begin
        if (sel.ok && op == OP_INVC) begin
            a_r3_cond_inv_reduces: assert ({res.ones, 1'b0} <= (CNT_W + 1)'(sel.width))
                else $error("R3 conditional invert left a majority of ones");
        end
        if (sel.ok && op == OP_FLPC) begin
            a_r5_cond_flip_reduces: assert (res.seg <= sel.seg)
                else $error("R5 conditional flip raised the segment value");
        end
    end
endmodule

// File: rtl/flag_pack.sv
module flag_pack
    import seg_codec_pkg::*;
(
    input  op_e               op,
    input  logic [FLAG_W-1:0] a_in,
    input  logic [FLAG_W-1:0] b_in,
    output logic [FLAG_W-1:0] packed_out,
    output logic [FLAG_W-1:0] hi_out,
    output logic [FLAG_W-1:0] lo_out
);
    localparam int PAIR_W = 2;

    always_comb begin
        packed_out = '0;
        hi_out     = '0;
        lo_out     = '0;
        if (op == OP_PACK) begin
            packed_out[2*PAIR_W-1:PAIR_W] = a_in[PAIR_W-1:0];
            packed_out[PAIR_W-1:0]        = b_in[PAIR_W-1:0];
        end
        if (op == OP_UNPACK) begin
            hi_out[PAIR_W-1:0] = a_in[2*PAIR_W-1:PAIR_W];
            lo_out[PAIR_W-1:0] = a_in[PAIR_W-1:0];
        end
    end
endmodule

// File: rtl/seg_codec_top.sv
module seg_codec_top
    import seg_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [1:0]        seg_size,
    input  logic [1:0]        seg_num,
    input  logic [15:0]       word_in,
    input  logic [7:0]        flag_a_in,
    input  logic [7:0]        flag_b_in,
    output logic              rsp_valid,
    output logic [15:0]       word_out,
    output logic [4:0]        ones_out,
    output logic [7:0]        flag_out,
    output logic [7:0]        split_a_out,
    output logic [7:0]        split_b_out
);
    op_e               op;
    seg_sel_t          sel;
    seg_res_t          res;
    logic [FLAG_W-1:0] pk_flags;
    logic [FLAG_W-1:0] pk_hi;
    logic [FLAG_W-1:0] pk_lo;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] mask_q;
    logic              enc;

    assign op = op_e'(cmd_op);

    seg_select u_sel (
        .size_code (seg_size),
        .seg_idx   (seg_num),
        .word      (word_in),
        .sel       (sel)
    );

    seg_transform u_xf (
        .op  (op),
        .sel (sel),
        .res (res)
    );

    flag_pack u_pk (
        .op         (op),
        .a_in       (flag_a_in),
        .b_in       (flag_b_in),
        .packed_out (pk_flags),
        .hi_out     (pk_hi),
        .lo_out     (pk_lo)
    );

    always_comb begin
        enc    = is_encode(op) && sel.ok;
        merged = word_in;
        if (enc) begin
            merged = (word_in & ~sel.mask) | (res.seg << sel.shift);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            word_out    <= '0;
            ones_out    <= '0;
            flag_out    <= '0;
            split_a_out <= '0;
            split_b_out <= '0;
            mask_q      <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                word_out    <= merged;
                ones_out    <= enc ? res.ones : '0;
                flag_out    <= enc ? FLAG_W'(res.flag) : pk_flags;
                split_a_out <= pk_hi;
                split_b_out <= pk_lo;
                mask_q      <= enc ? sel.mask : '0;
            end
        end
    end

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid) else $error("R10 missing response");
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid) else $error("R10 spurious response");
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(word_out) && $stable(flag_out) && $stable(ones_out))
        else $error("R10 outputs moved without a command");
    a_r11_outside_kept: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> ((word_out ^ $past(word_in)) & ~mask_q) == '0)
        else $error("R11 bits outside segment changed");
    a_r7_flag_narrow: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && is_encode(op) |=> flag_out[7:2] == '0 && ones_out <= 5'd16)
        else $error("R7 encode flag or count out of range");
    a_r9_split_narrow: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> split_a_out[7:2] == '0 && split_b_out[7:2] == '0)
        else $error("R9 unpack outputs too wide");
endmodule

// File: tb/seg_codec_top_tb.sv
module seg_codec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  seg_size = '0;
    logic [1:0]  seg_num = '0;
    logic [15:0] word_in = '0;
    logic [7:0]  flag_a_in = '0;
    logic [7:0]  flag_b_in = '0;
    logic        rsp_valid;
    logic [15:0] word_out;
    logic [4:0]  ones_out;
    logic [7:0]  flag_out;
    logic [7:0]  split_a_out;
    logic [7:0]  split_b_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_codec_top dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .seg_size(seg_size), .seg_num(seg_num), .word_in(word_in),
        .flag_a_in(flag_a_in), .flag_b_in(flag_b_in), .rsp_valid(rsp_valid),
        .word_out(word_out), .ones_out(ones_out), .flag_out(flag_out),
        .split_a_out(split_a_out), .split_b_out(split_b_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int sz, input int nm, input int w,
                         input int fa, input int fb);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        seg_size  = 2'(sz);
        seg_num   = 2'(nm);
        word_in   = 16'(w);
        flag_a_in = 8'(fa);
        flag_b_in = 8'(fb);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic int pop(input int v, input int w);
        int c = 0;
        for (int i = 0; i < w; i++) c += (v >> i) & 1;
        return c;
    endfunction

    function automatic int rev(input int v, input int w);
        int r = 0;
        for (int i = 0; i < w; i++) if ((v >> i) & 1) r |= 1 << (w - 1 - i);
        return r;
    endfunction

    task automatic run_encode(input int op, input int sz, input int nm, input int w);
        int width, lo, seg, nseg, ef, eo, ew, rv;
        string tag;
        issue(op, sz, nm, w, 0, 0);
        width = (sz < 3) ? (4 << sz) : 0;
        case (op)
            1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4"; 4: tag = "R5"; default: tag = "R6";
        endcase
        if (width == 0 || (nm + 1) * width > 16) begin
            check("R1 word", int'(word_out), w);
            check("R1 ones", int'(ones_out), 0);
            check("R1 flag", int'(flag_out), 0);
        end else begin
            lo   = nm * width;
            seg  = (w >> lo) & ((1 << width) - 1);
            rv   = rev(seg, width);
            nseg = seg;
            ef   = 0;
            if (op == 1 || (op == 2 && 2 * pop(seg, width) > width)) begin
                nseg = (~seg) & ((1 << width) - 1); ef = 1;
            end
            if (op == 3 || (op == 4 && seg > rv)) begin
                nseg = rv; ef = 2;
            end
            if (op == 5) begin
                nseg = rev((~seg) & ((1 << width) - 1), width); ef = 3;
            end
            eo = pop(nseg, width);
            ew = (w & ~(((1 << width) - 1) << lo) & 16'hFFFF) | (nseg << lo);
            check({tag, " R11 word"}, int'(word_out), ew);
            check({tag, " R7 ones"}, int'(ones_out), eo);
            check({tag, " R7 flag"}, int'(flag_out), ef);
            check("R9 split zero", int'(split_a_out) | int'(split_b_out), 0);
        end
        check("R10 valid", int'(rsp_valid), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", int'(rsp_valid), 0);
        check("R10 reset word", int'(word_out), 0);
        check("R10 reset flag", int'(flag_out) | int'(ones_out), 0);
        rst = 1'b0;

        for (int op = 1; op <= 5; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int nm = 0; nm < 4; nm++)
                    for (int k = 0; k < 48; k++) begin
                        int w;
                        if (k < 16) w = k * 16'h1111;
                        else w = ((k * 40503) ^ (k << 7)) & 16'hFFFF;
                        run_encode(op, sz, nm, w);
                    end

        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                issue(6, a & 3, b & 3, a * 4099 + b, 8'hF0 | a, 8'hA0 | b);
                check("R8 pack", int'(flag_out), ((a & 3) << 2) | (b & 3));
                check("R8 word", int'(word_out), (a * 4099 + b) & 16'hFFFF);
                check("R8 ones", int'(ones_out), 0);
                issue(7, 0, 0, b * 257, 8'hC0 | a, b);
                check("R9 hi", int'(split_a_out), a >> 2);
                check("R9 lo", int'(split_b_out), a & 3);
                check("R9 flag", int'(flag_out) | int'(ones_out), 0);
                check("R9 word", int'(word_out), b * 257);
            end

        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 7) continue;
            issue(op, 0, 0, 16'h5A3C, 8'hFF, 8'hFF);
            check("R10 unlisted word", int'(word_out), 16'h5A3C);
            check("R10 unlisted rest",
                  int'(flag_out) | int'(ones_out) | int'(split_a_out) | int'(split_b_out), 0);
        end

        issue(1, 0, 2, 16'h0F00, 0, 0);
        repeat (3) begin
            @(negedge clk);
            check("R10 idle valid", int'(rsp_valid), 0);
            check("R10 idle hold", int'(word_out), 16'h0000);
            check("R10 idle flag", int'(flag_out), 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule